// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer

This block is an 8-bit down-counting timer with a selectable prescaler, run entirely from a dedicated timer clock. A small control field picks one of four operating states and a prescale ratio. In the delay state the prescaled clock decrements the counter. In the event state each rising edge of an external input pin decrements it. In the pulse-width state the prescaled clock decrements it only while that pin is high. A time-constant register, loaded through a data write port, supplies the reload value, and the live count is always visible on an output bus.

Whenever the counter sits at 1 and receives one more count step, it expires. It reloads from the time constant, raises a one-cycle interrupt strobe and flips a square-wave output. When the timer is stopped it keeps its count but throws away whatever partial count the prescaler held. A data write while stopped also reloads the count directly. The external pin passes through a two-flop synchronizer before any edge detection. In the pulse-width state a falling edge on the pin gives a one-cycle end-of-pulse strobe.

The controller is a four-state machine: STOP, DELAY, EVENT and PULSE. Any state moves to any state, including itself, on a control write, and the target is taken from the mode field. With no control write the state is held. Reset enters STOP.

Top module: `mm_timer`

## Requirements
- R1: After reset the count is 0, the time constant is 0, tout is 0, irq and pw_end are 0, and the state is STOP.
- R2: A control write takes the mode from ctl_wdata[1:0] (00 STOP, 01 DELAY, 10 EVENT, 11 PULSE) and the prescale select from ctl_wdata[4:2] (codes 0 to 6 give ratios 4, 10, 16, 50, 64, 100, 200; code 7 gives 200). The new state acts from the next clock.
- R3: In DELAY, starting from a freshly cleared prescaler with count equal to the time constant T, irq is seen ratio*T clock edges after the edge that captured the control write.
- R4: When the count is 1 and a count step arrives, the count reloads from the time constant and irq is high for exactly one cycle.
- R5: tout inverts on every expiry and is otherwise unchanged.
- R6: A time constant of 0 acts as 256 counts, so a DELAY run with ratio 4 expires after 1024 edges.
- R7: In STOP the count does not change unless the data register is written.
- R8: A data write always loads the time constant. In STOP it also loads the count at the same edge. In a running state the count is left to continue.
- R9: Entering STOP clears the prescaler, so a restart takes a full ratio per count step regardless of any earlier partial prescale.
- R10: In EVENT each rising edge of ext_in decrements the count on the third clock edge after the input change, because of the two-flop synchronizer and the edge stage. Falling edges do not count.
- R11: In PULSE the prescaled clock advances only while the synchronized ext_in is high. The partial prescale count is kept while the input is low.
- R12: In PULSE a falling edge of ext_in gives pw_end high for one cycle. In other states pw_end stays low.
- R13: count_q always shows the live counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | {prescale select[2:0], mode[1:0]} |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Time constant value |
| ext_in | input | 1 | External event / gate input, asynchronous |
| count_q | output | 8 | Live count |
| tout | output | 1 | Square wave, inverts on each expiry |
| irq | output | 1 | One-cycle expiry strobe |
| pw_end | output | 1 | One-cycle end-of-pulse strobe in PULSE mode |

## Verification
The assertions check the following on every cycle. Each expiry is a single-cycle strobe that reloads the count with the time constant and inverts tout. tout never moves without an expiry. Outside a write or an expiry the count only ever steps down by one. A stopped timer holds its count, and pw_end never lasts longer than one cycle. The exact expiry periods for every prescale ratio, the 256-count meaning of zero, and the discarding of the prescale residue on stop can only be shown by the bench's scenarios. The same holds for the three-edge latency of event counting and for the prescale residue kept across an inactive pulse-width gate.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'b00,
        ST_DELAY = 2'b01,
        ST_EVENT = 2'b10,
        ST_PULSE = 2'b11
    } tmr_state_t;

    localparam int CNT_W = 8;
    localparam int SEL_W = 3;
    localparam int PRE_W = 8;

    // Prescale ratio for each select code; the last code repeats the largest.
    function automatic logic [PRE_W-1:0] pre_ratio(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] r;
        unique case (sel)
            3'd0:    r = 8'd4;
            3'd1:    r = 8'd10;
            3'd2:    r = 8'd16;
            3'd3:    r = 8'd50;
            3'd4:    r = 8'd64;
            3'd5:    r = 8'd100;
            default: r = 8'd200;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mm_timer_sync.sv
module mm_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/mm_timer_prescale.sv
module mm_timer_prescale
    import mm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last_val;

    assign last_val = pre_ratio(sel) - 8'd1;
    assign tick     = run && (pcnt >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pcnt <= '0;
        else if (clr) pcnt <= '0;
        else if (run) pcnt <= tick ? '0 : pcnt + 8'd1;
    end
endmodule

// File: rtl/mm_timer_counter.sv
module mm_timer_counter
    import mm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             stopped,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] tconst,
    output logic             expire,
    output logic             wave
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            tconst <= '0;
            expire <= 1'b0;
            wave   <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (ld_we) tconst <= ld_data;
            if (ld_we && stopped) begin
                count <= ld_data;
            end else if (step) begin
                if (count == ONE) begin
                    count  <= tconst;
                    expire <= 1'b1;
                    wave   <= ~wave;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [4:0] ctl_wdata,
    input  logic       data_we,
    input  logic [7:0] data_wdata,
    input  logic       ext_in,
    output logic [7:0] count_q,
    output logic       tout,
    output logic       irq,
    output logic       pw_end
);
    tmr_state_t       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] tconst_q;
    logic             in_lvl, in_rise, in_fall;
    logic             pre_clr, pre_run, pre_tick, step;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ctl_we) sel_q <= ctl_wdata[4:2];
        end
    end

    // Transitions: any state to the written mode on a control write
    always_comb begin
        state_d = state_q;
        if (ctl_we) state_d = tmr_state_t'(ctl_wdata[1:0]);
    end

    // Per-state outputs
    always_comb begin
        pre_clr = 1'b0;
        pre_run = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                pre_clr = 1'b1;
            end
            ST_DELAY: begin
                pre_run = 1'b1;
                step    = pre_tick;
            end
            ST_EVENT: begin
                pre_clr = 1'b1;
                step    = in_rise;
            end
            ST_PULSE: begin
                pre_run = in_lvl;
                step    = pre_tick;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_end <= 1'b0;
        else        pw_end <= (state_q == ST_PULSE) && in_fall;
    end

    mm_timer_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .lvl  (in_lvl),
        .rise (in_rise),
        .fall (in_fall)
    );

    mm_timer_prescale u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pre_clr),
        .run  (pre_run),
        .sel  (sel_q),
        .tick (pre_tick)
    );

    mm_timer_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_we  (data_we),
        .ld_data(data_wdata),
        .stopped(state_q == ST_STOP),
        .step   (step),
        .count  (count_q),
        .tconst (tconst_q),
        .expire (irq),
        .wave   (tout)
    );
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_we,
    input logic       stopped,
    input logic [7:0] count_q,
    input logic [7:0] tconst_q,
    input logic       tout,
    input logic       irq,
    input logic       pw_end
);
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_reload_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count_q == $past(tconst_q));

    p_tout_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tout != $past(tout));

    p_tout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(tout));

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stopped) && !$past(data_we)) |-> $stable(count_q));

    p_step_down_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(data_we) && !irq && count_q != $past(count_q))
            |-> count_q == $past(count_q) - 8'd1);

    p_pw_end_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pw_end |=> !pw_end);
endmodule

bind mm_timer mm_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (data_we),
    .stopped (state_q == mm_timer_pkg::ST_STOP),
    .count_q (count_q),
    .tconst_q(tconst_q),
    .tout    (tout),
    .irq     (irq),
    .pw_end  (pw_end)
);

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       ext_in = 1'b0;
    logic [7:0] count_q;
    logic       tout, irq, pw_end;

    int n_chk = 0;
    int n_bad = 0;
    int pw_seen = 0;
    bit done = 0;

    localparam logic [1:0] M_STOP = 2'b00, M_DELAY = 2'b01, M_EVENT = 2'b10, M_PULSE = 2'b11;

    // Stimulus table: prescale select, time constant, expected edges to expiry
    localparam int NV = 8;
    localparam int VSEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int VTC  [NV] = '{3, 2, 1, 2, 1, 1, 1, 1};
    localparam int VEXP [NV] = '{12, 20, 16, 100, 64, 100, 200, 200};

    always #2 clk = ~clk;

    mm_timer dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .ext_in(ext_in),
        .count_q(count_q), .tout(tout), .irq(irq), .pw_end(pw_end)
    );

    always @(negedge clk) if (pw_end) pw_seen++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [1:0] m, input logic [2:0] s);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = {s, m};
        @(posedge clk);
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk);
        data_we = 1'b1;
        data_wdata = v;
        @(posedge clk);
        @(negedge clk);
        data_we = 1'b0;
    endtask

    // Count edges until irq is seen at a falling edge
    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        logic t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(count_q == 0 && tout == 0 && irq == 0 && pw_end == 0, "R1 reset outputs",
            {count_q, tout, irq, pw_end}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(count_q == 0, "R1 stopped after reset", count_q, 0);

        // R2 R3 R4 R5 table walk over all prescale codes
        for (int i = 0; i < NV; i++) begin
            wr_ctl(M_STOP, 3'd0);
            wr_data(8'(VTC[i]));
            chk(count_q == 8'(VTC[i]), "R8 stopped write loads count", count_q, VTC[i]);
            t0 = tout;
            wr_ctl(M_DELAY, 3'(VSEL[i]));
            wait_irq(n);
            chk(n == VEXP[i], "R2 R3 delay period", n, VEXP[i]);
            chk(count_q == 8'(VTC[i]), "R4 reload value", count_q, VTC[i]);
            chk(tout == ~t0, "R5 tout flips", tout, ~t0);
            @(negedge clk);
            chk(irq == 0, "R4 irq one cycle", irq, 0);
        end

        // R6 zero time constant means 256
        wr_ctl(M_STOP, 3'd0);
        wr_data(8'd0);
        wr_ctl(M_DELAY, 3'd0);
        wait_irq(n);
        chk(n == 1024, "R6 zero is 256 counts", n, 1024);
        chk(count_q == 0, "R6 reload of zero", count_q, 0);

        // R8 data write while running leaves the count
        wr_ctl(M_STOP, 3'd0);
        wr_data(8'd5);
        wr_ctl(M_DELAY, 3'd0);
        wr_data(8'd9);
        chk(count_q == 8'd5, "R8 running write keeps count", count_q, 5);
        wait_irq(n);
        chk(count_q == 8'd9, "R8 new constant used on reload", count_q, 9);

        // R9 R7 stop discards prescale residue and holds count
        wr_ctl(M_STOP, 3'd0);
        wr_data(8'd2);
        wr_ctl(M_DELAY, 3'd0);
        wr_ctl(M_STOP, 3'd0);
        repeat (10) @(negedge clk);
        chk(count_q == 8'd2, "R7 stopped count held", count_q, 2);
        wr_ctl(M_DELAY, 3'd0);
        wait_irq(n);
        chk(n == 8, "R9 full period after stop", n, 8);
        chk(pw_seen == 0, "R12 no pw_end outside pulse mode", pw_seen, 0);

        // R10 event counting with latency
        wr_ctl(M_STOP, 3'd0);
        wr_data(8'd3);
        wr_ctl(M_EVENT, 3'd0);
        t0 = tout;
        @(negedge clk);
        ext_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(count_q == 8'd3, "R10 no count before third edge", count_q, 3);
        @(negedge clk);
        chk(count_q == 8'd2, "R10 count on third edge", count_q, 2);
        repeat (3) @(negedge clk);
        ext_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(count_q == 8'd2, "R10 falling edge ignored", count_q, 2);
        for (int k = 0; k < 2; k++) begin
            ext_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk(count_q == 8'd3 && tout == ~t0, "R10 R5 event expiry", count_q, 3);
        chk(pw_seen == 0, "R12 no pw_end in event mode", pw_seen, 0);

        // R11 R12 pulse-width mode
        wr_ctl(M_STOP, 3'd0);
        wr_data(8'd10);
        wr_ctl(M_PULSE, 3'd0);
        repeat (6) @(negedge clk);
        chk(count_q == 8'd10, "R11 idle while input low", count_q, 10);
        ext_in = 1'b1;
        repeat (22) @(negedge clk);
        ext_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(count_q == 8'd5, "R11 gated decrements", count_q, 5);
        chk(pw_seen == 1, "R12 one end strobe", pw_seen, 1);
        repeat (10) @(negedge clk);
        chk(count_q == 8'd5, "R11 hold while low", count_q, 5);
        ext_in = 1'b1;
        repeat (2) @(negedge clk);
        ext_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(count_q == 8'd4, "R11 residue kept", count_q, 4);
        chk(pw_seen == 2, "R12 second end strobe", pw_seen, 2);
        chk(count_q == 8'd4, "R13 live count", count_q, 4);

        finish_run();
    end
endmodule